// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short global record of the most recent branch outcomes and a table of small saturating counters. On a lookup, low-order bits of the branch address select a row of the table. The current global outcome pattern then selects one counter inside that row, and the upper bit of that counter is the prediction. With a history length of zero the block becomes a plain table of counters indexed only by the address.

When a branch resolves, the pipeline returns three items: the branch address, the real outcome, and the history value that the lookup port reported for that branch. The block moves exactly the one counter addressed by that pair one step towards the real outcome. It also shifts the outcome into the global record. The table has no tags, so branches whose index bits match share counters. Target addresses and the repair of speculative history are handled elsewhere.

Top module: `corr_bpred`

## Requirements
- R1: While reset is held and right after it is released, every counter holds the weakly not-taken value 2^(CTR_BITS-1)-1 (value 1 by default), so every lookup predicts not taken (`lkp_pred_taken`=0). The global history reads 0.
- R2: On each clock edge with `res_valid`=1, the history moves one place towards its MSB and `res_taken` enters at bit 0. The oldest outcome is dropped. Without `res_valid` the history does not change. Taken is written as 1 and not taken as 0.
- R3: A counter index is formed as {history, pc[PC_LSB +: ROW_W]}, with the history in the upper bits. By default this is {hist[1:0], pc[9:2]}. A lookup uses the live history. An update uses `res_hist`.
- R4: A taken resolution adds one to the addressed counter. The counter stays at 2^CTR_BITS-1 and does not wrap to 0.
- R5: A not-taken resolution subtracts one from the addressed counter. The counter stays at 0 and does not wrap to its maximum.
- R6: The prediction equals the MSB of the addressed counter. With 2-bit counters, values 2 and 3 predict taken and values 0 and 1 predict not taken.
- R7: A resolution changes only the counter at its own {res_hist, row} index. The counter for the same row under a different history value keeps its value.
- R8: Addresses that differ only outside the row field (for example in bit 12) map to the same counter and train it jointly.
- R9: A lookup in the same cycle as an update of its own counter returns the value from before the update.
- R10: `lkp_hist` always shows the live global history, so the pipeline can return it later as `res_hist`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkp_pc | input | PC_W | Address of the branch being predicted |
| lkp_pred_taken | output | 1 | Predicted direction, 1 = taken |
| lkp_hist | output | max(HIST_LEN,1) | Live global history, to be returned at resolution |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Real outcome, 1 = taken |
| res_hist | input | max(HIST_LEN,1) | History value captured at that branch's lookup |

## Verification
A corrupted history register appears on `lkp_hist` one cycle after the resolve that produced it. It also moves later lookups to the wrong counter in the row. A counter that steps the wrong way, or wraps at either end, first shows on `lkp_pred_taken` when that counter is next looked up under the same history. Because of this, the bench rebuilds the required history and then reads the counter back. Aliasing faults and faults that update the wrong counter show up only when a lookup is made under a history or address that the faulty logic has disturbed. Because of this, the bench reads neighbouring counters directly after each training sequence.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    // Direction encoding shared by the lookup and resolve paths.
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

    // History storage width; a zero-length history still keeps one bit.
    function automatic int unsigned hist_store_w(input int unsigned hlen);
        return (hlen > 0) ? hlen : 1;
    endfunction

endpackage

// File: rtl/cbp_history.sv
module cbp_history #(
    parameter int unsigned HIST_LEN = 2,
    parameter int unsigned HW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          shift_bit,
    output logic [HW-1:0] hist_o
);

    generate
        if (HIST_LEN > 0) begin : g_shift
            logic [HW-1:0] hist_q;
            logic [HW:0]   appended;

            assign appended = {hist_q, shift_bit};

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= appended[HW-1:0];
                end
            end

            assign hist_o = hist_q;
        end else begin : g_none
            logic unused_shift;
            assign unused_shift = ^{clk, rst_n, shift_en, shift_bit};
            assign hist_o = '0;
        end
    endgenerate

endmodule

// File: rtl/cbp_ctr_step.sv
module cbp_ctr_step #(
    parameter int unsigned CW = 2
) (
    input  logic [CW-1:0] cur_ctr,
    input  logic          go_up,
    output logic [CW-1:0] nxt_ctr
);

    localparam logic [CW-1:0] CTR_TOP = '1;
    localparam logic [CW-1:0] CTR_BOT = '0;

    always_comb begin
        nxt_ctr = cur_ctr;
        if (go_up) begin
            if (cur_ctr != CTR_TOP) begin
                nxt_ctr = cur_ctr + 1'b1;
            end
        end else begin
            if (cur_ctr != CTR_BOT) begin
                nxt_ctr = cur_ctr - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cbp_ctr_table.sv
module cbp_ctr_table #(
    parameter int unsigned CW      = 2,
    parameter int unsigned ENTRIES = 1024,
    parameter int unsigned IW      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [CW-1:0] rd_ctr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [CW-1:0] wr_ctr,
    output logic [CW-1:0] wr_old_ctr
);

    localparam logic [CW-1:0] WEAK_NT = CW'((1 << (CW - 1)) - 1);

    logic [CW-1:0] ctr_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < int'(ENTRIES); e++) begin
                ctr_q[e] <= WEAK_NT;
            end
        end else if (wr_en) begin
            for (int e = 0; e < int'(ENTRIES); e++) begin
                if (wr_idx == IW'(e)) begin
                    ctr_q[e] <= wr_ctr;
                end
            end
        end
    end

    assign rd_ctr     = ctr_q[rd_idx];
    assign wr_old_ctr = ctr_q[wr_idx];

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
    import cbp_pkg::*;
#(
    parameter int unsigned PC_W          = 32,
    parameter int unsigned HIST_LEN      = 2,
    parameter int unsigned CTR_BITS      = 2,
    parameter int unsigned TABLE_ENTRIES = 1024,
    parameter int unsigned PC_LSB        = 2,
    parameter int unsigned HW            = hist_store_w(HIST_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lkp_pc,
    output logic            lkp_pred_taken,
    output logic [HW-1:0]   lkp_hist,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [HW-1:0]   res_hist
);

    localparam int unsigned IDX_W = $clog2(TABLE_ENTRIES);
    localparam int unsigned ROW_W = IDX_W - HIST_LEN;

    logic [HW-1:0]       hist_cur;
    logic [IDX_W-1:0]    lkp_idx;
    logic [IDX_W-1:0]    upd_idx;
    logic [CTR_BITS-1:0] lkp_ctr;
    logic [CTR_BITS-1:0] upd_old_ctr;
    logic [CTR_BITS-1:0] upd_new_ctr;
    dir_e                res_dir;

    assign res_dir = dir_e'(res_taken);

    cbp_history #(
        .HIST_LEN (HIST_LEN),
        .HW       (HW)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (res_valid),
        .shift_bit (res_dir == DIR_TAKEN),
        .hist_o    (hist_cur)
    );

    generate
        if (HIST_LEN > 0) begin : g_corr_idx
            assign lkp_idx = {hist_cur, lkp_pc[PC_LSB +: ROW_W]};
            assign upd_idx = {res_hist, res_pc[PC_LSB +: ROW_W]};
        end else begin : g_flat_idx
            logic unused_res_hist;
            assign unused_res_hist = ^res_hist;
            assign lkp_idx = lkp_pc[PC_LSB +: ROW_W];
            assign upd_idx = res_pc[PC_LSB +: ROW_W];
        end
    endgenerate

    logic unused_pc_bits;
    assign unused_pc_bits = ^{lkp_pc, res_pc};

    cbp_ctr_step #(
        .CW (CTR_BITS)
    ) u_step (
        .cur_ctr (upd_old_ctr),
        .go_up   (res_dir == DIR_TAKEN),
        .nxt_ctr (upd_new_ctr)
    );

    cbp_ctr_table #(
        .CW      (CTR_BITS),
        .ENTRIES (TABLE_ENTRIES),
        .IW      (IDX_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (lkp_idx),
        .rd_ctr     (lkp_ctr),
        .wr_en      (res_valid),
        .wr_idx     (upd_idx),
        .wr_ctr     (upd_new_ctr),
        .wr_old_ctr (upd_old_ctr)
    );

    assign lkp_pred_taken = lkp_ctr[CTR_BITS-1];
    assign lkp_hist       = hist_cur;

endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned HW       = 2,
    parameter int unsigned CW       = 2,
    parameter int unsigned HIST_LEN = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lkp_pc,
    input logic            lkp_pred_taken,
    input logic [HW-1:0]   lkp_hist,
    input logic            res_valid,
    input logic            res_taken,
    input logic [CW-1:0]   upd_old,
    input logic [CW-1:0]   upd_new
);

    logic          armed_q;
    logic [HW:0]   shifted_cat;
    logic [HW-1:0] shifted_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign shifted_cat = {lkp_hist, res_taken};
    assign shifted_exp = shifted_cat[HW-1:0];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (lkp_hist == '0 && !lkp_pred_taken));

    generate
        if (HIST_LEN > 0) begin : g_hist_chk
            // R2
            ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid |=> lkp_hist == $past(shifted_exp));
        end else begin : g_flat_chk
            // R2
            ghr_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                lkp_hist == '0);
        end
    endgenerate

    // R2
    ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(lkp_hist));

    // R4
    ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken) |-> upd_new >= upd_old);

    // R5
    ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |-> upd_new <= upd_old);

    // R7
    pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !res_valid && $stable(lkp_pc)) |=> $stable(lkp_pred_taken));

endmodule

bind corr_bpred corr_bpred_chk #(
    .PC_W     (PC_W),
    .HW       (HW),
    .CW       (CTR_BITS),
    .HIST_LEN (HIST_LEN)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lkp_pc         (lkp_pc),
    .lkp_pred_taken (lkp_pred_taken),
    .lkp_hist       (lkp_hist),
    .res_valid      (res_valid),
    .res_taken      (res_taken),
    .upd_old        (upd_old_ctr),
    .upd_new        (upd_new_ctr)
);

// File: tb/tb_corr_bpred.sv
`timescale 1ns/1ps
module tb_corr_bpred;

    localparam int ROWS = 256;
    localparam int NVEC = 16;
    localparam logic [31:0] DUMMY_PC = 32'(255 << 2);

    // Stimulus: row number and outcome; expected prediction comes from the reference counters.
    localparam int       VEC_ROW [NVEC] = '{3, 3, 3, 3, 7, 7, 7, 7, 3, 3, 3, 3, 7, 7, 40, 40};
    localparam bit       VEC_TKN [NVEC] = '{1, 1, 1, 0, 1, 0, 1, 0, 1, 1, 1, 0, 1, 0, 1, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lkp_pc = '0;
    logic        lkp_pred_taken;
    logic [1:0]  lkp_hist;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [1:0]  res_hist = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int   mdl [1024];
    logic [1:0] mghr;

    always #4 clk = ~clk;

    corr_bpred dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .lkp_pc         (lkp_pc),
        .lkp_pred_taken (lkp_pred_taken),
        .lkp_hist       (lkp_hist),
        .res_valid      (res_valid),
        .res_pc         (res_pc),
        .res_taken      (res_taken),
        .res_hist       (res_hist)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int row_of(input logic [31:0] pc);
        return int'(pc[9:2]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) mdl[i] = 1;
        mghr = 2'b00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        res_valid = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic resolve(input logic [31:0] pc, input bit t, input logic [1:0] h);
        int idx;
        @(negedge clk);
        res_valid = 1'b1;
        res_pc = pc;
        res_taken = t;
        res_hist = h;
        @(posedge clk);
        #1;
        res_valid = 1'b0;
        idx = int'(h) * ROWS + row_of(pc);
        if (t && mdl[idx] < 3) mdl[idx]++;
        if (!t && mdl[idx] > 0) mdl[idx]--;
        mghr = {mghr[0], t};
    endtask

    task automatic set_ghr(input logic [1:0] h);
        resolve(DUMMY_PC, h[1], mghr);
        resolve(DUMMY_PC, h[0], mghr);
    endtask

    task automatic look_exp(input logic [31:0] pc, input bit exp, input string tag);
        @(negedge clk);
        lkp_pc = pc;
        #1;
        chk(lkp_pred_taken == exp, tag, int'(lkp_pred_taken), int'(exp));
        chk(lkp_hist == mghr, "R10 lookup history", int'(lkp_hist), int'(mghr));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: reset state
        repeat (2) @(negedge clk);
        #1;
        chk(lkp_hist == 2'b00, "R1 history during reset", int'(lkp_hist), 0);
        chk(lkp_pred_taken == 1'b0, "R1 prediction during reset", int'(lkp_pred_taken), 0);
        rst_n = 1'b1;
        look_exp(32'(0 << 2), 1'b0, "R1 row 0 weak not taken");
        look_exp(32'(5 << 2), 1'b0, "R1 row 5 weak not taken");
        look_exp(32'(200 << 2), 1'b0, "R1 row 200 weak not taken");

        // Vector table walk: R2 R3 R6 R9 R10 against the reference counters
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] pc;
            int idx;
            pc = 32'(VEC_ROW[i] << 2);
            idx = int'(mghr) * ROWS + VEC_ROW[i];
            @(negedge clk);
            lkp_pc = pc;
            res_valid = 1'b1;
            res_pc = pc;
            res_taken = VEC_TKN[i];
            res_hist = mghr;
            #1;
            // R9: same-cycle update is not yet visible
            chk(lkp_pred_taken == (mdl[idx] >= 2), "R9 R3 R6 vector prediction",
                int'(lkp_pred_taken), int'(mdl[idx] >= 2));
            chk(lkp_hist == mghr, "R10 vector history", int'(lkp_hist), int'(mghr));
            @(posedge clk);
            #1;
            res_valid = 1'b0;
            if (VEC_TKN[i] && mdl[idx] < 3) mdl[idx]++;
            if (!VEC_TKN[i] && mdl[idx] > 0) mdl[idx]--;
            mghr = {mghr[0], VEC_TKN[i]};
            // R2: history shifted with the outcome at bit 0
            chk(lkp_hist == mghr, "R2 history shift", int'(lkp_hist), int'(mghr));
        end

        // R2: no resolve, history holds
        repeat (3) @(negedge clk);
        #1;
        chk(lkp_hist == mghr, "R2 history hold", int'(lkp_hist), int'(mghr));

        // R1: mid-run reset restores weak not taken on trained row 3
        do_reset();
        look_exp(32'(3 << 2), 1'b0, "R1 trained row cleared");

        // R4: saturate at top
        for (int k = 0; k < 4; k++) resolve(32'(10 << 2), 1'b1, 2'b00);
        set_ghr(2'b00);
        look_exp(32'(10 << 2), 1'b1, "R4 saturated counter predicts taken");
        resolve(32'(10 << 2), 1'b0, 2'b00);
        set_ghr(2'b00);
        look_exp(32'(10 << 2), 1'b1, "R4 one step down from top stays taken");

        // R5: saturate at bottom, R6: msb decides
        resolve(32'(11 << 2), 1'b0, 2'b00);
        resolve(32'(11 << 2), 1'b0, 2'b00);
        set_ghr(2'b00);
        look_exp(32'(11 << 2), 1'b0, "R5 bottom counter predicts not taken");
        resolve(32'(11 << 2), 1'b1, 2'b00);
        set_ghr(2'b00);
        look_exp(32'(11 << 2), 1'b0, "R5 R6 value 1 predicts not taken");
        resolve(32'(11 << 2), 1'b1, 2'b00);
        set_ghr(2'b00);
        look_exp(32'(11 << 2), 1'b1, "R6 value 2 predicts taken");

        // R7: only the counter under history 1 changes
        resolve(32'(20 << 2), 1'b1, 2'b01);
        resolve(32'(20 << 2), 1'b1, 2'b01);
        set_ghr(2'b00);
        look_exp(32'(20 << 2), 1'b0, "R7 other history counter untouched");
        set_ghr(2'b10);
        look_exp(32'(20 << 2), 1'b0, "R7 history 2 counter untouched");
        set_ghr(2'b01);
        look_exp(32'(20 << 2), 1'b1, "R7 R3 trained counter under history 1");

        // R8: aliasing through bit 12
        resolve(32'((21 << 2) | (1 << 12)), 1'b1, 2'b10);
        resolve(32'((21 << 2) | (1 << 12)), 1'b1, 2'b10);
        set_ghr(2'b10);
        look_exp(32'(21 << 2), 1'b1, "R8 aliased address shares counter");
        look_exp(32'(22 << 2), 1'b0, "R8 neighbour row unaffected");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule